// File: doc/BRIEF.md
# Four-Quadrant Flyback PWM Sequencer

This block is the digital switching core of a bidirectional flyback inverter with a bipolar output. The converter has one primary switch and two secondary switches: one for the positive side and one for the negative side. Each period, the block takes a signed reference sample and a signed error sample. It picks one of four operating modes from their two signs. It turns the error magnitude into a duty word and compares that word against a down-counting ramp to form a leading-edge pulse. It then routes the pulse, and a synchronous-rectifier enable when one is needed, to the gate output that suits the mode.

A switching period lasts twice the programmed half length. The first half is the modulation half. Here the pulse takes up the last cycles, so it always ends on the boundary into the second half. The second half is kept for core reset. In the forward modes the rectifying switch turns on exactly at that boundary, and it is released one cycle before the period ends. This leaves a dead cycle ahead of the next pulse. Mode, duty and half length are all sampled once, at the start of each period.

Top module: `fqfb_pwm_seq`

## Requirements
- R1: Mode is taken from the two sample signs. Reference ≥ 0 with error ≥ 0 gives mode 1 (`mode_o`=0). Reference ≥ 0 with error < 0 gives mode 2 (`mode_o`=1). Reference < 0 with error < 0 gives mode 3 (`mode_o`=2). Reference < 0 with error ≥ 0 gives mode 4 (`mode_o`=3).
- R2: The forward modes modulate the primary switch. Mode 1 then uses the positive-side switch as rectifier, and mode 3 uses the negative-side switch.
- R3: The reverse modes hold the primary switch off and use no rectifier. Mode 2 modulates the negative-side switch and mode 4 modulates the positive-side switch.
- R4: A period is 2·H cycles, where H is `half_len_i` (a value of 0 is treated as 1). The duty D is min(|error| >> SHIFT, H). The modulated gate is high in the last D cycles of the first H cycles, so it falls on the half-period boundary and never covers more than half the period.
- R5: At most one gate output is high in any cycle.
- R6: In a forward mode with D > 0, the rectifier gate is high from the first cycle of the second half for H−1 cycles. The final cycle of every period has all gates low.
- R7: Mode, duty and H are sampled only at the start of a period. A change to the inputs in mid-period has no effect until the next period.
- R8: When D = 0, no gate goes high during that period.
- R9: When `en` is low, all gates are low in that same cycle, and `mode_o` reads 0 from the next clock edge. When `en` is raised again, a new period starts at the next edge.
- R10: While `rst_n` is low, all gates are low and `mode_o` is 0.
- R11: The most negative error code gives a full magnitude, with no wrap to zero, and so the duty is capped at H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable |
| ref_smp_i | input | W | Signed reference sample |
| err_smp_i | input | W | Signed error sample |
| half_len_i | input | CW | Half-period length in cycles |
| g_pri_o | output | 1 | Primary switch gate |
| g_pos_o | output | 1 | Positive-side secondary switch gate |
| g_neg_o | output | 1 | Negative-side secondary switch gate |
| mode_o | output | 2 | Current mode, 0..3 for modes 1..4 |

## Verification
The bench compares every cycle of whole periods with a model built from the requirements. It covers all four sign combinations, so a swapped mode table would drive the wrong secondary switch and short the output. It changes the error sign and the half length in mid-period: a design that samples them continuously would cut a pulse short or move the boundary. It also checks the dead final cycle and a full-width pulse at the cap. A design missing either of these would have the rectifier overlap the next pulse, or would exceed 50% duty. Further cases are zero duty, the most negative error code, and dropping `en` while a pulse is high. A design that gets these wrong would emit a stray rectifier pulse, produce a wrapped zero duty, or leave a gate driven after disable.

// File: rtl/fqfb_pwm_seq.sv
module fqfb_pwm_seq #(
  parameter int W     = 12,
  parameter int CW    = 10,
  parameter int SHIFT = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic signed [W-1:0] ref_smp_i,
  input  logic signed [W-1:0] err_smp_i,
  input  logic [CW-1:0]       half_len_i,
  output logic                g_pri_o,
  output logic                g_pos_o,
  output logic                g_neg_o,
  output logic [1:0]          mode_o
);

  localparam int MW = (W > CW) ? W : CW;

  logic          run_q;
  logic [CW:0]   p_q;
  logic [CW-1:0] h_q, duty_q;
  logic [1:0]    mode_q;

  logic          ref_neg, err_neg;
  logic [W-1:0]  eu, mag, sh;
  logic [MW-1:0] sh_x, h_x;
  logic [CW-1:0] h_in, duty_n, ramp;
  logic [CW:0]   last_p;
  logic          in_mod, fwd, active, pwm, rect;

  assign ref_neg = ref_smp_i < 0;
  assign err_neg = err_smp_i < 0;
  assign eu      = err_smp_i;
  assign mag     = err_neg ? (~eu + {{(W-1){1'b0}}, 1'b1}) : eu;
  assign sh      = mag >> SHIFT;
  assign h_in    = (half_len_i == '0) ? {{(CW-1){1'b0}}, 1'b1} : half_len_i;
  assign sh_x    = MW'(sh);
  assign h_x     = MW'(h_in);
  assign duty_n  = (sh_x > h_x) ? h_in : sh_x[CW-1:0];

  assign last_p  = {h_q, 1'b0} - {{CW{1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      p_q    <= '0;
      h_q    <= {{(CW-1){1'b0}}, 1'b1};
      duty_q <= '0;
      mode_q <= 2'd0;
    end else if (!en) begin
      run_q  <= 1'b0;
      p_q    <= '0;
      mode_q <= 2'd0;
    end else if (!run_q || p_q == last_p) begin
      run_q  <= 1'b1;
      p_q    <= '0;
      h_q    <= h_in;
      duty_q <= duty_n;
      mode_q <= {ref_neg, ref_neg ^ err_neg};
    end else begin
      p_q <= p_q + {{CW{1'b0}}, 1'b1};
    end
  end

  assign in_mod = p_q < {1'b0, h_q};
  assign ramp   = h_q - p_q[CW-1:0];
  assign fwd    = ~mode_q[0];
  assign active = en && run_q && duty_q != '0;
  assign pwm    = active && in_mod && ramp <= duty_q;
  assign rect   = active && fwd && !in_mod && p_q != last_p;

  assign g_pri_o = pwm && fwd;
  assign g_pos_o = (pwm && mode_q == 2'd3) || (rect && mode_q == 2'd0);
  assign g_neg_o = (pwm && mode_q == 2'd1) || (rect && mode_q == 2'd2);
  assign mode_o  = mode_q;

  p_one_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({g_pri_o, g_pos_o, g_neg_o}) <= 1);

  p_mode_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_o) |-> (p_q == '0 || !run_q));

  p_pri_fall_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(g_pri_o) && en && run_q) |-> (p_q == {1'b0, h_q}));

  p_dead_after_rect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rect |=> !g_pri_o && !(g_pos_o && mode_q == 2'd3) && !(g_neg_o && mode_q == 2'd1));

  p_zero_duty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && duty_q == '0) |-> !(g_pri_o || g_pos_o || g_neg_o));

  p_disable_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> mode_o == 2'd0);

endmodule

// File: tb/fqfb_pwm_seq_tb_top.sv
`timescale 1ns/1ps
module fqfb_pwm_seq_tb_top;
  localparam int W = 12, CW = 10;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic signed [W-1:0] rf = '0, er = '0;
  logic [CW-1:0] hl = 10'd8;
  logic gp, gs, gn;
  logic [1:0] md;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fqfb_pwm_seq #(.W(W), .CW(CW), .SHIFT(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .ref_smp_i(rf), .err_smp_i(er),
    .half_len_i(hl), .g_pri_o(gp), .g_pos_o(gs), .g_neg_o(gn), .mode_o(md));

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", rq, act, exp, $time);
    end
  endtask

  function automatic int exp_g(int m, int d, int h, int p);
    bit pwm, rect;
    pwm  = (d > 0) && (p < h) && ((h - p) <= d);
    rect = (d > 0) && (m == 0 || m == 2) && (p >= h) && (p < 2*h - 1);
    return {pwm && (m == 0 || m == 2),
            (pwm && m == 3) || (rect && m == 0),
            (pwm && m == 1) || (rect && m == 2)};
  endfunction

  task automatic start(input int r, input int e, input int h);
    @(negedge clk); en = 1'b0; rf = W'(r); er = W'(e); hl = CW'(h);
    @(negedge clk); en = 1'b1;
  endtask

  task automatic one_cycle(input int m, input int d, input int h, input int p, input string rq);
    int g;
    @(negedge clk);
    g = {gp, gs, gn};
    chk(g == exp_g(m, d, h, p), rq, g, exp_g(m, d, h, p));
    chk(md == 2'(m), "R1 mode", md, m);
    chk($countones({gp, gs, gn}) <= 1, "R5 one gate", g, 0);
  endtask

  task automatic period(input int m, input int d, input int h, input string rq);
    for (int p = 0; p < 2*h; p++) one_cycle(m, d, h, p, rq);
  endtask

  task automatic t_reset;
    en = 1'b1; rf = 12'sd100; er = 12'sd5;
    repeat (3) @(negedge clk);
    chk({gp, gs, gn} == 3'b000, "R10 gates in reset", {gp, gs, gn}, 0);
    chk(md == 2'd0, "R10 mode in reset", md, 0);
    en = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_modes;
    start(100, 3, 8);   period(0, 3, 8, "R2 mode1");
    start(100, -5, 8);  period(1, 5, 8, "R3 mode2");
    start(-100, -2, 8); period(2, 2, 8, "R2 mode3");
    start(-100, 4, 8);  period(3, 4, 8, "R3 mode4");
    start(-1, 0, 6);    period(3, 0, 6, "R1 zero error is nonnegative");
  endtask

  task automatic t_cap;
    start(100, 1000, 8);  period(0, 8, 8, "R4 duty cap at half");
    start(-50, -7, 4);    period(2, 4, 4, "R6 dead cycle after full pulse");
    start(100, -2048, 8); period(1, 8, 8, "R11 most negative error");
    start(100, 3, 0);     period(0, 1, 1, "R4 zero half length as one");
  endtask

  task automatic t_zero;
    start(100, 0, 8);  period(0, 0, 8, "R8 zero duty mode1");
    start(-100, 0, 5); period(3, 0, 5, "R8 zero duty mode4");
  endtask

  task automatic t_midchange;
    start(100, 3, 8);
    for (int p = 0; p < 16; p++) begin
      one_cycle(0, 3, 8, p, "R7 inputs held in period");
      if (p == 2) begin er = -12'sd5; hl = 10'd5; end
    end
    period(1, 5, 5, "R7 new values at boundary");
  endtask

  task automatic t_disable;
    start(-100, -2, 8);
    for (int p = 0; p < 7; p++) one_cycle(2, 2, 8, p, "R2 before disable");
    en = 1'b0;
    #1;
    chk({gp, gs, gn} == 3'b000, "R9 gates off same cycle", {gp, gs, gn}, 0);
    @(negedge clk);
    chk(md == 2'd0, "R9 mode cleared", md, 0);
    chk({gp, gs, gn} == 3'b000, "R9 gates stay off", {gp, gs, gn}, 0);
    en = 1'b1;
    period(2, 2, 8, "R9 restart from period start");
  endtask

  initial begin
    t_reset;
    t_modes;
    t_cap;
    t_zero;
    t_midchange;
    t_disable;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule